// File: doc/BRIEF.md
# I2C Slave Control Register Interface

This block gives a host on a two-wire I2C bus access to a small bank of control registers. The bus pins arrive as open-drain signals: the slave sees each line level as an input and pulls SDA low through a drive-enable output. A strap pin sets the least significant bit of the 7-bit device address, so two copies can share one bus. Both bus lines are resynchronised and deglitched in the system clock domain, which runs at least ten times faster than SCL.

A write transfer first loads a register pointer. Each data byte after it goes to the register that the pointer selects, and the pointer then advances, so a single transfer can fill several consecutive registers. A read transfer returns bytes from the pointer onward and advances the pointer after every byte until the master stops acknowledging. Parameter masks mark some bits as read-only or reserved, and the bank discards host writes to them. Read-only bits read back live status from an input vector. Every register index at or above the bank size is reserved as a whole.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1,0,0,0,1,0 followed by the level of `addr_sel_i`. Bit 0 of that byte selects read (1) or write (0). With `addr_sel_i`=0 the write/read bytes are 0x88/0x89, and with `addr_sel_i`=1 they are 0x8A/0x8B.
- R2: On a non-matching address the slave leaves SDA released during the acknowledge clock and through every later byte up to the next START. Registers are not changed.
- R3: In a write, the first byte after the address loads the register pointer and writes no register.
- R4: Each further write byte is acknowledged and goes to the register at the pointer, after which the pointer increments by one.
- R5: Bits marked in `RO_MASK` ignore host writes. A read returns the matching bits of `ro_val_i` in those positions. In the default configuration these are bits 7:4 of register 1.
- R6: Bits marked in `RSV_MASK` ignore writes and read as 0. In the default configuration these are bits 1:0 of register 2. Register indices at or above `NUM_REGS` ignore writes and read as 0x00.
- R7: A read returns the register at the pointer MSB first and increments the pointer after each byte. After a master NACK the slave stops driving SDA.
- R8: A repeated START returns the slave to the address phase and leaves the pointer unchanged.
- R9: A STOP returns the slave to idle with SDA released. Outside START and STOP the slave changes SDA only while SCL is low.
- R10: After reset SDA is released and every register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 1 | Device address bit 0 |
| ro_val_i | input | NUM_REGS*8 | Status values read back in read-only bit positions, register i at bits [8i+7:8i] |
| regs_o | output | NUM_REGS*8 | Writable register contents, with read-only and reserved bits at 0 |

## Verification
The assertions run on every cycle. They check that the slave changes SDA only while the filtered SCL is low, and that it releases SDA right after a START or STOP. They also check that register outputs move only in the cycle after a write strobe, that a write strobe to a reserved index leaves them unchanged, and that every strobe comes with the pointer one past the written index. The bench scenarios show what no single-cycle property can capture. These are the address match with the strap pin at each level, the pointer load from the first write byte, burst writes and reads across consecutive registers, the masking of read-only and reserved bits, a repeated START that keeps the pointer, and release after a NACK.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } i2c_st_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b100010;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_i};
      if (sync_q[1] == out_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_o <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_sel_i,
  input  logic [7:0] rdata_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  i2c_st_e    st_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       rw_q, first_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
        first_q  <= 1'b1;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                  rw_q     <= sh_q[0];
                  sda_oe_o <= 1'b1;
                  st_q     <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_WACK;
                if (first_q) begin
                  ptr_o   <= sh_q;
                  first_q <= 1'b0;
                end else begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_o;
                  wr_data_o <= sh_q;
                  ptr_o     <= ptr_o + 1'b1;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q     <= rdata_i;
                ptr_o    <= ptr_o + 1'b1;
                sda_oe_o <= ~rdata_i[7];
                st_q     <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
                cnt_q    <= cnt_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                sh_q     <= rdata_i;
                ptr_o    <= ptr_o + 1'b1;
                sda_oe_o <= ~rdata_i[7];
                cnt_q    <= '0;
                st_q     <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int                      NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0]   RO_MASK  = '0,
  parameter logic [NUM_REGS*8-1:0]   RSV_MASK = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [7:0]            rd_addr_i,
  input  logic [NUM_REGS*8-1:0] ro_val_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RO = RO_MASK[g*8 +: 8];
    localparam logic [7:0] RS = RSV_MASK[g*8 +: 8];
    localparam logic [7:0] WM = ~RO & ~RS;
    logic [7:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && wr_addr_i == 8'(g)) q <= (q & ~WM) | (wr_data_i & WM);
    end

    assign view[g]         = (q & WM) | (ro_val_i[g*8 +: 8] & RO & ~RS);
    assign regs_o[g*8 +: 8] = q & WM;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr_i == 8'(i)) rd_data_o = view[i];
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int                    NUM_REGS = 4,
  parameter int                    FILT_LEN = 3,
  parameter logic [NUM_REGS*8-1:0] RO_MASK  = 'h0000_F000,
  parameter logic [NUM_REGS*8-1:0] RSV_MASK = 'h0003_0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  addr_sel_i,
  input  logic [NUM_REGS*8-1:0] ro_val_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [1:0] line_raw, line_f;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start, stop;
  logic [7:0] ptr, wr_addr, wr_data, rdata;
  logic       wr_en;

  assign line_raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (line_raw[l]),
      .out_o (line_f[l])
    );
  end

  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  i2c_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  i2c_slave_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_f),
    .start_i   (start),
    .stop_i    (stop),
    .addr_sel_i(addr_sel_i),
    .rdata_i   (rdata),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  i2c_reg_bank #(
    .NUM_REGS(NUM_REGS),
    .RO_MASK (RO_MASK),
    .RSV_MASK(RSV_MASK)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(ptr),
    .ro_val_i (ro_val_i),
    .rd_data_o(rdata),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_f,
  input logic                  start,
  input logic                  stop,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [7:0]            wr_addr,
  input logic [7:0]            ptr,
  input logic [NUM_REGS*8-1:0] regs_o
);
  // R9
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start) && !$past(stop)) |-> !scl_f);

  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe_o);

  // R8
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_oe_o);

  // R5
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(regs_o));

  // R6
  rsv_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(regs_o));

  // R4
  ptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ptr == wr_addr + 8'd1);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_f   (scl_f),
  .start   (start),
  .stop    (stop),
  .sda_oe_o(sda_oe_o),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ptr     (ptr),
  .regs_o  (regs_o)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int NUM_REGS = 4;
  localparam int Q = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mscl = 1'b1, msda = 1'b1, sel = 1'b0;
  logic sda_oe;
  logic [NUM_REGS*8-1:0] regs;
  logic [NUM_REGS*8-1:0] ro_val = 32'hA5A5_A5A5;
  wire  sda_line = msda & ~sda_oe;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  i2c_reg_slave #(.NUM_REGS(NUM_REGS)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (mscl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .addr_sel_i(sel),
    .ro_val_i  (ro_val),
    .regs_o    (regs)
  );

  // {ptr, data written, expected read}
  localparam logic [23:0] VEC [7] = '{
    24'h00_3C_3C, 24'h01_FF_AF, 24'h02_FF_FC, 24'h03_81_81,
    24'h05_77_00, 24'h01_00_A0, 24'h02_03_00
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start;
    wq(Q); msda = 1'b1; wq(Q); mscl = 1'b1; wq(2*Q); msda = 1'b0; wq(2*Q); mscl = 1'b0;
  endtask

  task automatic i2c_stop;
    wq(Q); msda = 1'b0; wq(Q); mscl = 1'b1; wq(2*Q); msda = 1'b1; wq(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); msda = b[i]; wq(Q); mscl = 1'b1; wq(2*Q); mscl = 1'b0;
    end
    wq(Q); msda = 1'b1; wq(Q); mscl = 1'b1; wq(Q); ack = !sda_line; wq(Q); mscl = 1'b0;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); msda = 1'b1; wq(Q); mscl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); mscl = 1'b0;
    end
    wq(Q); msda = !ack; wq(Q); mscl = 1'b1; wq(2*Q); mscl = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    wq(5);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 sda released", {31'd0, sda_oe}, 0);
    chk(regs == '0, "R10 regs zero", regs, 0);
    rst_n = 1'b1;
    wq(5);

    // table: write one byte at ptr, read back
    for (int v = 0; v < 7; v++) begin
      i2c_start;
      wr_byte(8'h88, a); chk(a, "R1 addr ack", {31'd0, a}, 1);
      wr_byte(VEC[v][23:16], a); chk(a, "R3 ptr ack", {31'd0, a}, 1);
      wr_byte(VEC[v][15:8], a); chk(a, "R4 data ack", {31'd0, a}, 1);
      i2c_stop;
      i2c_start;
      wr_byte(8'h88, a);
      wr_byte(VEC[v][23:16], a);
      i2c_start;
      wr_byte(8'h89, a); chk(a, "R1 read addr ack", {31'd0, a}, 1);
      rd_byte(1'b0, d);
      chk(d == VEC[v][7:0], "R5 R6 R7 readback", {24'd0, d}, {24'd0, VEC[v][7:0]});
      i2c_stop;
    end
    chk(regs == 32'h8100_003C, "R5 R6 regs after table", regs, 32'h8100_003C);

    // R1 select pin high
    sel = 1'b1;
    i2c_start;
    wr_byte(8'h8A, a); chk(a, "R1 sel=1 ack", {31'd0, a}, 1);
    wr_byte(8'h00, a);
    wr_byte(8'h5A, a);
    i2c_stop;
    chk(regs[7:0] == 8'h5A, "R1 sel=1 write", {24'd0, regs[7:0]}, 32'h5A);

    // R2 non-matching address
    i2c_start;
    wr_byte(8'h88, a); chk(!a, "R2 no ack", {31'd0, a}, 0);
    wr_byte(8'h00, a); chk(!a, "R2 data no ack", {31'd0, a}, 0);
    wr_byte(8'h99, a);
    i2c_stop;
    chk(regs[7:0] == 8'h5A, "R2 regs unchanged", {24'd0, regs[7:0]}, 32'h5A);
    sel = 1'b0;

    // R4 burst write
    i2c_start;
    wr_byte(8'h88, a);
    wr_byte(8'h00, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    wr_byte(8'h44, a); chk(a, "R4 last burst ack", {31'd0, a}, 1);
    i2c_stop;
    chk(regs == 32'h4430_0211, "R4 burst regs", regs, 32'h4430_0211);

    // R7 R8 burst read after repeated start
    i2c_start;
    wr_byte(8'h88, a);
    wr_byte(8'h01, a);
    i2c_start;
    wr_byte(8'h89, a); chk(a, "R8 restart addr ack", {31'd0, a}, 1);
    rd_byte(1'b1, d); chk(d == 8'hA2, "R8 ptr kept", {24'd0, d}, 32'hA2);
    rd_byte(1'b1, d); chk(d == 8'h30, "R7 second byte", {24'd0, d}, 32'h30);
    rd_byte(1'b0, d); chk(d == 8'h44, "R7 third byte", {24'd0, d}, 32'h44);
    wq(Q);
    chk(sda_oe == 1'b0, "R7 release after nack", {31'd0, sda_oe}, 0);
    i2c_stop;

    // R6 pointer continues into reserved index 4
    i2c_start;
    wr_byte(8'h89, a);
    rd_byte(1'b0, d); chk(d == 8'h00, "R6 reserved reg read", {24'd0, d}, 0);
    i2c_stop;
    chk(sda_oe == 1'b0, "R9 released after stop", {31'd0, sda_oe}, 0);
    chk(regs == 32'h4430_0211, "R9 regs stable", regs, 32'h4430_0211);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule